// File: doc/BRIEF.md
# Rotate-Extend-Accumulate Datapath Unit

This unit is a purely combinational 32-bit datapath slice for the byte and halfword extend operations of an integer execution pipe. A source word is first rotated right by a whole number of bytes, with bits wrapping from the bottom back to the top. A byte or halfword is then taken from the bottom of the rotated word and widened with either sign or zero fill. The widened value can be added to a second operand word.

A packed dual-lane form takes two bytes at once, from rotated bits 7..0 and 23..16. It widens each byte into its own 16-bit lane. When accumulating, each lane is added to the matching half of the second operand, and the two lane sums are kept apart. Operation selection, rotation and both operands arrive together, and the result settles in the same cycle. Predication, decoding and flag generation are handled by the surrounding pipe.

Top module: `rxa_unit`

## Requirements
- R1: The source word `src_in` is rotated right by 8 × `rot_sel` bits, wrapping around. With `rot_sel`=3, the halfword forms therefore see source bits 7..0 as the upper byte and source bits 31..24 as the lower byte.
- R2: `op_code` bit 3 selects accumulate (1) or plain (0), and bit 2 selects signed (1) or unsigned (0). Bits 1..0 select the form: 0 is byte, 1 is halfword and 2 is dual-byte.
- R3: The byte forms place rotated bits 7..0 in result bits 7..0. The signed form copies bit 7 into bits 31..8, and the unsigned form clears bits 31..8.
- R4: The halfword forms place rotated bits 15..0 in result bits 15..0. The signed form copies bit 15 into bits 31..16, and the unsigned form clears bits 31..16.
- R5: The accumulating byte and halfword forms output the extended value plus `acc_in`, modulo 2^32.
- R6: The dual-byte forms put rotated bits 7..0 into the low 16-bit lane and rotated bits 23..16 into the high lane. Each byte is sign-extended (signed) or zero-extended (unsigned) to 16 bits.
- R7: Accumulating dual-byte adds the low lane to `acc_in[15:0]` and the high lane to `acc_in[31:16]`, each modulo 2^16. No carry passes from the low lane into the high lane.
- R8: Any code with bits 1..0 equal to 3 outputs zero, whatever the operands and the accumulate bit.
- R9: The result depends only on the present inputs. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_in | input | 32 | Word to be rotated and extended |
| acc_in | input | 32 | Addend for the accumulating forms |
| rot_sel | input | 2 | Rotation amount in bytes |
| op_code | input | 4 | Accumulate, signedness and form select |
| result | output | 32 | Extended or accumulated result |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 8-bit rotation steps and a 2-bit rotation selector. These values give four rotations and two 16-bit lanes, so every rotation, both lanes and all sixteen operation codes can be reached. The operands set the top bit of the extracted byte or halfword, force both word and per-lane overflow, and fill unused source bits with patterns that must not leak into the result.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    FORM_BYTE = 2'd0,
    FORM_HALF = 2'd1,
    FORM_DUAL = 2'd2,
    FORM_NONE = 2'd3
  } form_e;
endpackage

// File: rtl/rxa_rotator.sv
module rxa_rotator #(
  parameter int W     = 32,
  parameter int STEP  = 8,
  parameter int SEL_W = 2
) (
  input  logic [W-1:0]     src,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     rotated
);
  localparam int N = 1 << SEL_W;
  logic [W-1:0] cand [N];

  for (genvar g = 0; g < N; g++) begin : g_amt
    localparam int SH = g * STEP;
    if (SH == 0) begin : g_zero
      assign cand[g] = src;
    end else begin : g_rot
      assign cand[g] = {src[SH-1:0], src[W-1:SH]};
    end
  end

  assign rotated = cand[sel];
endmodule

// File: rtl/rxa_extend.sv
module rxa_extend
  import rxa_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0] rotated,
  input  form_e        form,
  input  logic         sgn,
  output logic [W-1:0] ext
);
  localparam int HALF_W = W / 2;
  localparam int DUAL_PAD = HALF_W - BYTE_W;

  logic lo_byte_msb, hi_byte_msb, half_msb;
  assign lo_byte_msb = sgn & rotated[BYTE_W-1];
  assign hi_byte_msb = sgn & rotated[HALF_W+BYTE_W-1];
  assign half_msb    = sgn & rotated[HALF_W-1];

  always_comb begin
    unique case (form)
      FORM_BYTE: ext = {{(W-BYTE_W){lo_byte_msb}}, rotated[BYTE_W-1:0]};
      FORM_HALF: ext = {{(W-HALF_W){half_msb}}, rotated[HALF_W-1:0]};
      FORM_DUAL: ext = {{DUAL_PAD{hi_byte_msb}}, rotated[HALF_W+BYTE_W-1:HALF_W],
                        {DUAL_PAD{lo_byte_msb}}, rotated[BYTE_W-1:0]};
      default:   ext = '0;
    endcase
  end
endmodule

// File: rtl/rxa_accum.sv
module rxa_accum #(
  parameter int W      = 32,
  parameter int LANE_W = 16
) (
  input  logic [W-1:0] ext,
  input  logic [W-1:0] addend,
  input  logic         acc_en,
  input  logic         lane_mode,
  output logic [W-1:0] sum
);
  localparam int LANES = W / LANE_W;
  logic [W-1:0] word_sum;
  logic [W-1:0] lane_sum;

  assign word_sum = ext + addend;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_sum[l*LANE_W +: LANE_W] =
      ext[l*LANE_W +: LANE_W] + addend[l*LANE_W +: LANE_W];
  end

  always_comb begin
    if (!acc_en)        sum = ext;
    else if (lane_mode) sum = lane_sum;
    else                sum = word_sum;
  end
endmodule

// File: rtl/rxa_unit.sv
module rxa_unit
  import rxa_pkg::*;
#(
  parameter int W     = 32,
  parameter int STEP  = 8,
  parameter int SEL_W = 2
) (
  input  logic [W-1:0]     src_in,
  input  logic [W-1:0]     acc_in,
  input  logic [SEL_W-1:0] rot_sel,
  input  logic [3:0]       op_code,
  output logic [W-1:0]     result
);
  localparam int LANE_W = W / 2;

  form_e        form;
  logic         sgn, acc_en;
  logic [W-1:0] rotated, ext, sum;

  assign form   = form_e'(op_code[1:0]);
  assign sgn    = op_code[2];
  assign acc_en = op_code[3];

  rxa_rotator #(.W(W), .STEP(STEP), .SEL_W(SEL_W)) u_rot (
    .src(src_in), .sel(rot_sel), .rotated(rotated));

  rxa_extend #(.W(W), .BYTE_W(STEP)) u_ext (
    .rotated(rotated), .form(form), .sgn(sgn), .ext(ext));

  rxa_accum #(.W(W), .LANE_W(LANE_W)) u_acc (
    .ext(ext), .addend(acc_in), .acc_en(acc_en),
    .lane_mode(form == FORM_DUAL), .sum(sum));

  assign result = (form == FORM_NONE) ? '0 : sum;
endmodule

// File: rtl/rxa_unit_chk.sv
module rxa_unit_chk (
  input logic [31:0] src_in,
  input logic [1:0]  rot_sel,
  input logic [3:0]  op_code,
  input logic [31:0] result
);
  always_comb begin
    if (op_code[1:0] == 2'd3)
      assert_unused_zero_R8: assert (result == 32'h0);
    if (op_code == 4'h0)
      assert_ubyte_pick_R1: assert (result == {24'h0, src_in[rot_sel*8 +: 8]});
    if (op_code == 4'h1 && rot_sel == 2'd3)
      assert_wrap_half_R1: assert (result == {16'h0, src_in[7:0], src_in[31:24]});
    if (op_code == 4'h4)
      assert_sbyte_fill_R3: assert (result[31:8] == {24{result[7]}});
    if (op_code == 4'h5)
      assert_shalf_fill_R4: assert (result[31:16] == {16{result[15]}});
    if (op_code == 4'h1)
      assert_uhalf_fill_R4: assert (result[31:16] == 16'h0);
    if (op_code == 4'h6)
      assert_sdual_fill_R6: assert (result[15:8] == {8{result[7]}}
                                     && result[31:24] == {8{result[23]}});
    if (op_code == 4'h2)
      assert_udual_fill_R6: assert (result[15:8] == 8'h0 && result[31:24] == 8'h0);
  end
endmodule

bind rxa_unit rxa_unit_chk u_chk (
  .src_in(src_in), .rot_sel(rot_sel), .op_code(op_code), .result(result));

// File: tb/rxa_unit_tb.sv
module rxa_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] src_in, acc_in, result;
  logic [1:0]  rot_sel;
  logic [3:0]  op_code;

  rxa_unit u_dut (.src_in(src_in), .acc_in(acc_in), .rot_sel(rot_sel),
                  .op_code(op_code), .result(result));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // fields: src, acc, rot, op, expected
  localparam int NV = 14;
  localparam logic [101:0] VEC [NV] = '{
    {32'h12345680, 32'h0,        2'd0, 4'h4, 32'hFFFFFF80}, // R3 signed byte
    {32'h12345680, 32'h0,        2'd0, 4'h0, 32'h00000080}, // R3 unsigned byte
    {32'h12345680, 32'h0,        2'd3, 4'h5, 32'hFFFF8012}, // R1 R4 wrap halfword
    {32'h12345680, 32'h0,        2'd3, 4'h1, 32'h00008012}, // R1 R4
    {32'h000000FF, 32'h00000001, 2'd0, 4'hC, 32'h00000000}, // R5 signed byte acc
    {32'h0000FFFF, 32'hFFFF0001, 2'd0, 4'h9, 32'h00000000}, // R5 word wrap
    {32'h11802280, 32'h0,        2'd0, 4'h6, 32'hFF80FF80}, // R6 signed dual
    {32'h11802280, 32'h0,        2'd0, 4'h2, 32'h00800080}, // R6 unsigned dual
    {32'h00FF00FF, 32'h0001FFFF, 2'd0, 4'hA, 32'h010000FE}, // R7 low lane overflow
    {32'h80AABBCC, 32'h0,        2'd1, 4'h6, 32'hFF80FFBB}, // R6 R1 rotated dual
    {32'hFFFFFFFF, 32'h12345678, 2'd2, 4'hB, 32'h00000000}, // R8
    {32'hFFFFFFFF, 32'h12345678, 2'd1, 4'h7, 32'h00000000}, // R8
    {32'h00AB0000, 32'h0,        2'd2, 4'h0, 32'h000000AB}, // R1 R3
    {32'h00800000, 32'h00010000, 2'd1, 4'hD, 32'h00008000}  // R5 signed half acc
  };
  localparam int VTAG [NV] = '{3, 3, 4, 4, 5, 5, 6, 6, 7, 6, 8, 8, 1, 5};

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] a,
                                        logic [1:0] r, logic [3:0] op);
    logic [63:0] dbl;
    logic [31:0] w, e;
    logic [15:0] lo, hi;
    dbl = {s, s} >> (int'(r) * 8);
    w = dbl[31:0];
    lo = op[2] ? 16'($signed(w[7:0]))   : {8'h0, w[7:0]};
    hi = op[2] ? 16'($signed(w[23:16])) : {8'h0, w[23:16]};
    case (op[1:0])
      2'd0: e = op[2] ? 32'($signed(w[7:0]))  : {24'h0, w[7:0]};
      2'd1: e = op[2] ? 32'($signed(w[15:0])) : {16'h0, w[15:0]};
      2'd2: e = op[3] ? {hi + a[31:16], lo + a[15:0]} : {hi, lo};
      default: return 32'h0;
    endcase
    if (op[3] && op[1:0] != 2'd2) e = e + a;
    return e;
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op[1:0])
      2'd0: return op[3] ? "R5" : "R3";
      2'd1: return op[3] ? "R5" : "R4";
      2'd2: return op[3] ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(logic [31:0] s, logic [31:0] a, logic [1:0] r,
                       logic [3:0] op, logic [31:0] exp, string tag);
    @(posedge clk);
    src_in = s; acc_in = a; rot_sel = r; op_code = op;
    @(negedge clk);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h rot=%0d src=%h acc=%h: got %h expected %h",
               tag, op, r, s, a, result, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired: got hang expected completion");
    n_run++;
    finish_run();
  end

  localparam logic [31:0] SRCS [4] = '{32'h80FF7F01, 32'h7F80FF00, 32'hC3A5815A, 32'hFFFFFFFF};
  localparam logic [31:0] ACCS [4] = '{32'hFFFFFFFF, 32'h8000FFFF, 32'h7FFF7FFF, 32'h00010001};

  initial begin
    src_in = '0; acc_in = '0; rot_sel = '0; op_code = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: idle inputs give zero, with no stored state to clear
    apply(32'h0, 32'h0, 2'd0, 4'h0, 32'h0, "R9");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][101:70], VEC[i][69:38], VEC[i][37:36], VEC[i][35:32],
            VEC[i][31:0], $sformatf("R%0d", VTAG[i]));
    end

    // R2: full sweep of codes and rotations against the model
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 16; op++)
        for (int r = 0; r < 4; r++)
          apply(SRCS[k], ACCS[k], 2'(r), 4'(op),
                model(SRCS[k], ACCS[k], 2'(r), 4'(op)), tag_of(4'(op)));

    // R9: result follows an input change back and forth
    apply(32'h000000F0, 32'h0, 2'd0, 4'h4, 32'hFFFFFFF0, "R9");
    apply(32'h00000070, 32'h0, 2'd0, 4'h4, 32'h00000070, "R9");
    apply(32'h000000F0, 32'h0, 2'd0, 4'h4, 32'hFFFFFFF0, "R9");
    // R7: high lane overflow is dropped, low lane intact
    apply(32'h00800001, 32'hFF800001, 2'd0, 4'hE, 32'hFF000002, "R7");
    finish_run();
  end
endmodule